// File: doc/BRIEF.md
# Sign-Aware Leading-Bit Normalization Unit

This unit sits in the DSP execute stage, in parallel with memory access. It takes a 40-bit accumulator value: an 8-bit guard extension above a 32-bit base word. It reports how far that value must be shifted so that bit 31 is the last copy of the sign and bit 30 is the first significant bit. Every operand bit is examined, the guard bits included. A value whose significance has spilled into the guard extension therefore yields a negative amount, which means a right shift is needed.

The amount is delivered as DSP integer data. It is a two's-complement 16-bit number in the upper word of the base part, bits 31:16. Bits 15:0 are always zero. The guard field either repeats the sign of the amount or, when the destination register has no guard extension, is forced to zero so that only the upper word carries information. Status flags describe the integer result. The unit registers its outputs, so the result appears one clock after the input strobe.

Top module: `msb_norm`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge, and low otherwise.
- R2: Let p be the highest bit index, from 38 down to 0, whose value differs from operand bit 39. The shift amount is 30 − p, so the range is −8 to +30 for such operands.
- R3: An operand whose 40 bits are all equal (all zeros or all ones) yields the fixed shift amount +31.
- R4: The shift amount is written as a 16-bit two's-complement integer in result bits 31:16, and result bits 15:0 are always zero.
- R5: With `in_no_guard` low, result bits 39:32 are all copies of result bit 31.
- R6: With `in_no_guard` high, result bits 39:32 are zero and bits 31:0 are the same as they would be with `in_no_guard` low.
- R7: `out_flag_n` equals the sign of the shift amount (result bit 31), and `out_flag_z` is high exactly when the shift amount is zero.
- R8: `out_flag_v` is always low.
- R9: After a clock edge with `rst_n` low, `out_valid`, `out_result` and all flags are zero.
- R10: While `in_valid` is low, `out_result` and the flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 40 | Guard-extended accumulator operand (bits 39:32 guard) |
| in_no_guard | input | 1 | High when the destination has no guard bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 40 | Shift amount in integer format |
| out_flag_n | output | 1 | Negative flag of the shift amount |
| out_flag_z | output | 1 | Zero flag of the shift amount |
| out_flag_v | output | 1 | Overflow flag, always clear |

## Verification
The only state in this unit is the output register, so every internal fault shows up in the very next `out_valid` cycle. A wrong sign-difference vector or a wrong priority pick produces a shift amount that is off for operands whose leading significant bit sits in a specific region, such as the guard field, bit 30 or bit 0. For that reason the stimulus places that bit at each region edge and also covers the equal-bit extremes. A formatting fault appears as nonzero low bits, a guard field that disagrees with bit 31 or ignores `in_no_guard`, or flags that disagree with the upper word.

// File: rtl/msb_norm_pkg.sv
// Shared types for the normalization unit.
// Assumes: the flag bundle is common to all DSP result formatters.
package msb_norm_pkg;

    // Status bits produced alongside an integer result
    typedef struct packed {
        logic n;
        logic z;
        logic v;
    } msbn_flags_t;

endpackage

// File: rtl/msbn_diff.sv
// Marks every operand bit below the top bit that differs from the top bit.
// Assumes: the top bit of the operand is its sign.
module msbn_diff #(
    parameter int OP_W = 40
) (
    input  logic [OP_W-1:0] operand,
    output logic [OP_W-2:0] diff
);

    // One comparator per bit position
    for (genvar g = 0; g < OP_W - 1; g++) begin : g_cmp
        assign diff[g] = operand[g] ^ operand[OP_W-1];
    end

endmodule

// File: rtl/msbn_prio.sv
// Finds the index of the highest set bit of a vector.
// Assumes: when no bit is set, idx is zero and found is low.
module msbn_prio #(
    parameter int W     = 39,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // Upward scan so that the highest set bit is the last one kept
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msbn_format.sv
// Turns a leading-bit index into a signed shift amount and packs it as
// DSP integer data: guard | upper word | zero lower word, plus flags.
// Assumes: GUARD_W + INT_W + LOW_W == OP_W.
module msbn_format
    import msb_norm_pkg::*;
#(
    parameter int OP_W    = 40,
    parameter int GUARD_W = 8,
    parameter int INT_W   = 16,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             found,
    input  logic             no_guard,
    output logic [OP_W-1:0]  word,
    output msbn_flags_t      flags
);

    localparam int BASE_W    = OP_W - GUARD_W;
    localparam int LOW_W     = BASE_W - INT_W;
    localparam int NORM_POS  = BASE_W - 2;
    localparam int MAX_SHIFT = BASE_W - 1;

    logic [INT_W-1:0]   shift;
    logic [GUARD_W-1:0] guard;

    // Shift amount: distance from the found bit to the normalized position
    always_comb begin
        if (found) begin
            shift = INT_W'(NORM_POS) - INT_W'(idx);
        end else begin
            shift = INT_W'(MAX_SHIFT);
        end
    end

    // Guard field: sign copies, or zero for a destination without guard bits
    always_comb begin
        if (no_guard) begin
            guard = '0;
        end else begin
            guard = {GUARD_W{shift[INT_W-1]}};
        end
    end

    // Pack the result word and its flags
    always_comb begin
        word    = {guard, shift, {LOW_W{1'b0}}};
        flags.n = shift[INT_W-1];
        flags.z = (shift == '0);
        flags.v = 1'b0;
    end

endmodule

// File: rtl/msb_norm.sv
// Single-stage normalization shift detector for a guard-extended operand.
// Assumes: one operand per cycle at most. Outputs change only on a strobe.
module msb_norm
    import msb_norm_pkg::*;
#(
    parameter int OP_W    = 40,
    parameter int GUARD_W = 8,
    parameter int INT_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_operand,
    input  logic            in_no_guard,
    output logic            out_valid,
    output logic [OP_W-1:0] out_result,
    output logic            out_flag_n,
    output logic            out_flag_z,
    output logic            out_flag_v
);

    localparam int SCAN_W = OP_W - 1;
    localparam int IDX_W  = $clog2(SCAN_W);

    logic [SCAN_W-1:0] diff;
    logic [IDX_W-1:0]  lead_idx;
    logic              lead_found;
    logic [OP_W-1:0]   word_c;
    msbn_flags_t       flags_c;
    msbn_flags_t       flags_q;

    msbn_diff #(.OP_W(OP_W)) u_diff (
        .operand (in_operand),
        .diff    (diff)
    );

    msbn_prio #(.W(SCAN_W), .IDX_W(IDX_W)) u_prio (
        .vec   (diff),
        .idx   (lead_idx),
        .found (lead_found)
    );

    msbn_format #(
        .OP_W    (OP_W),
        .GUARD_W (GUARD_W),
        .INT_W   (INT_W),
        .IDX_W   (IDX_W)
    ) u_fmt (
        .idx      (lead_idx),
        .found    (lead_found),
        .no_guard (in_no_guard),
        .word     (word_c),
        .flags    (flags_c)
    );

    // Valid pipeline bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Result and flag register, loaded only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            flags_q    <= '0;
        end else if (in_valid) begin
            out_result <= word_c;
            flags_q    <= flags_c;
        end
    end

    assign out_flag_n = flags_q.n;
    assign out_flag_z = flags_q.z;
    assign out_flag_v = flags_q.v;

endmodule

// File: rtl/msb_norm_chk.sv
// Port-level properties of the normalization unit, bound to msb_norm.
// Assumes: reset is applied before the first strobe.
module msb_norm_chk #(
    parameter int OP_W    = 40,
    parameter int GUARD_W = 8,
    parameter int INT_W   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] in_operand,
    input logic            in_no_guard,
    input logic            out_valid,
    input logic [OP_W-1:0] out_result,
    input logic            out_flag_n,
    input logic            out_flag_z,
    input logic            out_flag_v
);

    localparam int BASE_W = OP_W - GUARD_W;
    localparam int LOW_W  = BASE_W - INT_W;
    localparam logic signed [INT_W-1:0] MIN_S = -$signed(INT_W'(GUARD_W));
    localparam logic signed [INT_W-1:0] MAX_S = $signed(INT_W'(BASE_W - 1));

    logic signed [INT_W-1:0] amt;
    assign amt = out_result[BASE_W-1:LOW_W];

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_amount_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (amt >= MIN_S && amt <= MAX_S));
    assert_flat_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(in_operand) == '0 || $past(in_operand) == '1)
        |-> amt == MAX_S);
    assert_low_word_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_result[LOW_W-1:0] == '0);
    assert_guard_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(in_no_guard)
        |-> out_result[OP_W-1:BASE_W] == {GUARD_W{out_result[BASE_W-1]}});
    assert_guard_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_no_guard) |-> out_result[OP_W-1:BASE_W] == '0);
    assert_flags_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flag_n == amt[INT_W-1]) && (out_flag_z == (amt == '0)));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_flag_v);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_flag_n) && $stable(out_flag_z));

endmodule

bind msb_norm msb_norm_chk #(
    .OP_W    (OP_W),
    .GUARD_W (GUARD_W),
    .INT_W   (INT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .in_no_guard (in_no_guard),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_flag_n  (out_flag_n),
    .out_flag_z  (out_flag_z),
    .out_flag_v  (out_flag_v)
);

// File: tb/sim_msb_norm.sv
module sim_msb_norm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] in_operand = '0;
    logic        in_no_guard = 1'b0;
    logic        out_valid;
    logic [39:0] out_result;
    logic        out_flag_n;
    logic        out_flag_z;
    logic        out_flag_v;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    msb_norm u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_no_guard (in_no_guard),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_flag_n  (out_flag_n),
        .out_flag_z  (out_flag_z),
        .out_flag_v  (out_flag_v)
    );

    // Expected result word computed from R2..R6
    function automatic logic [39:0] model(input logic [39:0] op, input logic ng);
        int          sh;
        logic [15:0] s;
        logic [7:0]  g;
        sh = 31;
        for (int i = 38; i >= 0; i--) begin
            if (op[i] != op[39]) begin
                sh = 30 - i;
                break;
            end
        end
        s = 16'(sh);
        g = ng ? 8'h00 : {8{s[15]}};
        return {g, s, 16'h0000};
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full output comparison after one strobe (R1, R4..R8 each time)
    task automatic run_one(input string req, input logic [39:0] op, input logic ng);
        logic [39:0] e;
        e = model(op, ng);
        @(negedge clk);
        in_valid    = 1'b1;
        in_operand  = op;
        in_no_guard = ng;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R1 valid"}, 40'(out_valid), 40'd1);
        check({req, " word"}, out_result, e);
        check({req, " R7 N"}, 40'(out_flag_n), 40'(e[31]));
        check({req, " R7 Z"}, 40'(out_flag_z), 40'(e[31:16] == 16'h0));
        check({req, " R8 V"}, 40'(out_flag_v), 40'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 valid", 40'(out_valid), 40'd0);
        check("R9 result", out_result, 40'd0);
        check("R9 flags", 40'({out_flag_n, out_flag_z, out_flag_v}), 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 40'(out_valid), 40'd0);
    endtask

    task automatic test_positive();
        run_one("R2 normalized", 40'h00_4000_0000, 1'b0);
        check("R2 zero amount", out_result, 40'h00_0000_0000);
        run_one("R2 bit0", 40'h00_0000_0001, 1'b0);
        check("R2 thirty", out_result, 40'h00_001E_0000);
        run_one("R2 bit15", 40'h00_0000_8000, 1'b0);
        run_one("R2 neg bit0", 40'hFF_FFFF_FFFE, 1'b0);
        run_one("R2 neg normalized", 40'hFF_8000_0000, 1'b0);
    endtask

    task automatic test_guard();
        run_one("R5 top guard", 40'h7F_0000_0000, 1'b0);
        check("R5 minus eight", out_result, 40'hFF_FFF8_0000);
        run_one("R5 bit32", 40'h01_0000_0000, 1'b0);
        run_one("R5 neg guard", 40'h80_0000_0000, 1'b0);
    endtask

    task automatic test_flat();
        run_one("R3 zeros", 40'h00_0000_0000, 1'b0);
        check("R3 zeros 31", out_result, 40'h00_001F_0000);
        run_one("R3 ones", 40'hFF_FFFF_FFFF, 1'b0);
        check("R3 ones 31", out_result, 40'h00_001F_0000);
    endtask

    task automatic test_no_guard();
        run_one("R6 negative", 40'h7F_0000_0000, 1'b1);
        check("R6 upper only", out_result, 40'h00_FFF8_0000);
        run_one("R6 positive", 40'h00_0000_0100, 1'b1);
    endtask

    task automatic test_hold();
        logic [39:0] kept;
        run_one("R10 load", 40'hC0_0000_0000, 1'b0);
        kept = out_result;
        in_operand = 40'h00_0000_0001;
        repeat (4) @(negedge clk);
        check("R10 hold result", out_result, kept);
        check("R10 hold valid", 40'(out_valid), 40'd0);
        check("R10 hold N", 40'(out_flag_n), 40'd1);
    endtask

    // Back-to-back strobes each produce their own result
    task automatic test_stream();
        @(negedge clk);
        in_valid = 1'b1;
        in_operand = 40'h00_2000_0000;
        in_no_guard = 1'b0;
        @(negedge clk);
        check("R1 stream a", out_result, 40'h00_0001_0000);
        in_operand = 40'h03_0000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 stream b valid", 40'(out_valid), 40'd1);
        check("R2 stream b", out_result, 40'hFF_FFFD_0000);
        @(negedge clk);
        check("R1 stream end", 40'(out_valid), 40'd0);
    endtask

    initial begin
        test_reset();
        test_positive();
        test_guard();
        test_flat();
        test_no_guard();
        test_hold();
        test_stream();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule